// File: doc/BRIEF.md
# ODT Minimum High Time Monitor

This block watches the on-die termination enable that a memory controller drives toward a DRAM device, and it checks that the enable never drops too early. The monitor samples the ODT level and the write command strobe on every clock. Each write carries a flag that tells a chopped four-beat burst from a full eight-beat burst. Once ODT goes high it must stay high for a minimum number of cycles. A write seen while ODT is high starts a new minimum, and the burst type of that write sets its length. The longest outstanding minimum is the one that counts.

When ODT is sampled low while a minimum is still running, the monitor raises a one-cycle pulse and a sticky flag, and it records which rule was broken. The monitor only observes. It never alters the ODT signal, so it can sit next to a controller in silicon or in a prototype and catch scheduling bugs.

Top module: `odt_hold_monitor`

## Requirements
- R1: Reset (rstN low) drives violPulse, violFlag and violCode to 0 and sets the tracked ODT level to low. An ODT level already high on the first clock after reset therefore counts as a rising edge.
- R2: After ODT is sampled high following a low sample, a low sample earlier than HOLD_RISE (default 4) cycles after that rising sample is a violation with violCode = 1. A low sample exactly HOLD_RISE cycles later is legal.
- R3: A write with wrChop = 1 (chopped 4-beat) sampled while ODT is high requires ODT to stay high until at least HOLD_CHOP (default 4) cycles after the write. A shorter hold is a violation with violCode = 2.
- R4: A write with wrChop = 0 (full 8-beat) sampled while ODT is high requires ODT to stay high until at least HOLD_FULL (default 6) cycles after the write. A shorter hold is a violation with violCode = 3.
- R5: The hold that applies is the latest deadline among all outstanding requirements. A new event can extend the hold but never shorten it.
- R6: A write sampled while ODT is low starts no requirement.
- R7: violCode reports the rule with the latest deadline at the moment of the violation. When a write's deadline equals the rising-edge deadline, the write's code is reported. violFlag high implies a nonzero violCode, and violCode changes only together with a violation pulse or a clear.
- R8: violPulse is high for exactly the one cycle after the clock edge that samples the early low. violFlag rises at the same time and stays high until clear or reset, and further compliant or violating activity does not drop it.
- R9: A clear sampled high zeroes violFlag, violPulse, violCode and every outstanding hold in the next cycle. Level tracking continues, so ODT held high across a clear is not treated as a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of flag, code and holds |
| odtIn | input | 1 | ODT level as driven to the memory |
| wrValid | input | 1 | A write command is issued this cycle |
| wrChop | input | 1 | 1 = chopped 4-beat write, 0 = full 8-beat write |
| violPulse | output | 1 | One-cycle pulse on a detected violation |
| violFlag | output | 1 | Sticky violation flag |
| violCode | output | 2 | Rule of the last violation: 0 none, 1 rise, 2 chop write, 3 full write |

## Verification
The properties assume that odtIn, wrValid, wrChop and clear are synchronous to clk and settle before each rising edge. They also assume that clear is never high in the same cycle that reset is released. The stimulus changes every input only on the falling clock edge and pulses clear on its own between scenarios. The one exception is the directed case that checks a clear issued while ODT is held high. The relation between a pulse and the two earlier ODT samples is therefore only checked with clear low, and no scenario puts a clear and an early low in the same cycle.

// File: rtl/odt_hold_pkg.sv
package odt_hold_pkg;

  typedef enum logic [1:0] {
    RULE_NONE = 2'd0,
    RULE_RISE = 2'd1,
    RULE_CHOP = 2'd2,
    RULE_FULL = 2'd3
  } odtRule_e;

  typedef struct packed {
    logic high;
    logic rise;
    logic fall;
    logic wrChopEv;
    logic wrFullEv;
    logic clr;
  } odtStrobes_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/odt_hold_ctrl.sv
module odt_hold_ctrl
  import odt_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        odtIn,
  input  logic        wrValid,
  input  logic        wrChop,
  output odtStrobes_t stb
);

  logic prevOdt;

  // Level tracking keeps running through a clear; only reset forces low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevOdt <= 1'b0;
    else       prevOdt <= odtIn;
  end

  always_comb begin
    stb.high     = odtIn;
    stb.rise     = odtIn & ~prevOdt;
    stb.fall     = ~odtIn & prevOdt;
    stb.wrChopEv = wrValid & odtIn & wrChop;
    stb.wrFullEv = wrValid & odtIn & ~wrChop;
    stb.clr      = clear;
  end

endmodule

// File: rtl/odt_hold_dp.sv
module odt_hold_dp
  import odt_hold_pkg::*;
#(
  parameter int HOLD_RISE = 4,
  parameter int HOLD_CHOP = 4,
  parameter int HOLD_FULL = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  odtStrobes_t stb,
  output logic        violPulse,
  output logic        violFlag,
  output odtRule_e    violCode
);

  localparam int HOLD_MAX = maxOf3(HOLD_RISE, HOLD_CHOP, HOLD_FULL);
  localparam int CNT_W    = $clog2(HOLD_MAX + 1);
  localparam int NRULES   = 3;

  // Remaining high cycles after the event cycle itself.
  localparam logic [CNT_W-1:0] LEN_RISE = CNT_W'(HOLD_RISE - 1);
  localparam logic [CNT_W-1:0] LEN_CHOP = CNT_W'(HOLD_CHOP - 1);
  localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(HOLD_FULL - 1);

  logic [CNT_W-1:0] remCnt;
  odtRule_e         curRule;
  logic [CNT_W-1:0] remDec;
  logic [CNT_W-1:0] bestLen;
  odtRule_e         bestRule;

  logic             evHit  [NRULES];
  logic [CNT_W-1:0] evLen  [NRULES];
  odtRule_e         evRule [NRULES];

  // Candidate order sets tie priority: later entries win on equal length.
  assign evHit[0]  = stb.rise;
  assign evLen[0]  = LEN_RISE;
  assign evRule[0] = RULE_RISE;
  assign evHit[1]  = stb.wrChopEv;
  assign evLen[1]  = LEN_CHOP;
  assign evRule[1] = RULE_CHOP;
  assign evHit[2]  = stb.wrFullEv;
  assign evLen[2]  = LEN_FULL;
  assign evRule[2] = RULE_FULL;

  assign remDec = (remCnt == '0) ? '0 : remCnt - 1'b1;

  always_comb begin
    bestLen  = remDec;
    bestRule = curRule;
    for (int k = 0; k < NRULES; k++) begin
      if (evHit[k] && (evLen[k] >= bestLen)) begin
        bestLen  = evLen[k];
        bestRule = evRule[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt    <= '0;
      curRule   <= RULE_NONE;
      violPulse <= 1'b0;
      violFlag  <= 1'b0;
      violCode  <= RULE_NONE;
    end else if (stb.clr) begin
      remCnt    <= '0;
      curRule   <= RULE_NONE;
      violPulse <= 1'b0;
      violFlag  <= 1'b0;
      violCode  <= RULE_NONE;
    end else begin
      violPulse <= 1'b0;
      if (stb.high) begin
        remCnt  <= bestLen;
        curRule <= bestRule;
      end else begin
        remCnt  <= '0;
        curRule <= RULE_NONE;
      end
      if (stb.fall && (remCnt != '0)) begin
        violPulse <= 1'b1;
        violFlag  <= 1'b1;
        violCode  <= curRule;
      end
    end
  end

endmodule

// File: rtl/odt_hold_monitor.sv
module odt_hold_monitor
  import odt_hold_pkg::*;
#(
  parameter int HOLD_RISE = 4,
  parameter int HOLD_CHOP = 4,
  parameter int HOLD_FULL = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       odtIn,
  input  logic       wrValid,
  input  logic       wrChop,
  output logic       violPulse,
  output logic       violFlag,
  output logic [1:0] violCode
);

  odtStrobes_t stb;
  odtRule_e    codeQ;

  odt_hold_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (clear),
    .odtIn   (odtIn),
    .wrValid (wrValid),
    .wrChop  (wrChop),
    .stb     (stb)
  );

  odt_hold_dp #(
    .HOLD_RISE (HOLD_RISE),
    .HOLD_CHOP (HOLD_CHOP),
    .HOLD_FULL (HOLD_FULL)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .violPulse (violPulse),
    .violFlag  (violFlag),
    .violCode  (codeQ)
  );

  assign violCode = codeQ;

endmodule

// File: rtl/odt_hold_monitor_chk.sv
module odt_hold_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       clear,
  input logic       odtIn,
  input logic       violPulse,
  input logic       violFlag,
  input logic [1:0] violCode
);

  a_r8_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> violFlag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (violFlag && !clear) |=> violFlag);

  a_r8_pulse_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    (violPulse && !$past(clear)) |-> (!$past(odtIn) && $past(odtIn, 2)));

  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!violFlag && !violPulse && violCode == 2'd0));

  a_r7_flag_has_code: assert property (@(posedge clk) disable iff (!rstN)
    violFlag |-> (violCode != 2'd0));

  a_r7_code_changes_on_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> (violPulse || $stable(violCode)));

endmodule

bind odt_hold_monitor odt_hold_monitor_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .clear     (clear),
  .odtIn     (odtIn),
  .violPulse (violPulse),
  .violFlag  (violFlag),
  .violCode  (violCode)
);

// File: tb/odt_hold_monitor_test.sv
module odt_hold_monitor_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clear = 1'b0;
  logic       odtIn = 1'b0;
  logic       wrValid = 1'b0;
  logic       wrChop = 1'b0;
  logic       violPulse;
  logic       violFlag;
  logic [1:0] violCode;

  int checks = 0;
  int fails = 0;
  int pulseCount = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  odt_hold_monitor uut (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .odtIn     (odtIn),
    .wrValid   (wrValid),
    .wrChop    (wrChop),
    .violPulse (violPulse),
    .violFlag  (violFlag),
    .violCode  (violCode)
  );

  // Vector: {highLen[3:0], wrAt[3:0] (15 = none), wrChop, expFlag, expCode[1:0]}
  localparam int NVEC = 13;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd4, 4'd15, 1'b0, 1'b0, 2'd0},  // R2 exact rise hold
    {4'd3, 4'd15, 1'b0, 1'b1, 2'd1},  // R2 one short
    {4'd1, 4'd15, 1'b0, 1'b1, 2'd1},  // R2 single-cycle pulse
    {4'd6, 4'd2,  1'b1, 1'b0, 2'd0},  // R3 exact chop hold
    {4'd5, 4'd2,  1'b1, 1'b1, 2'd2},  // R3 one short
    {4'd8, 4'd2,  1'b0, 1'b0, 2'd0},  // R4 exact full hold
    {4'd7, 4'd2,  1'b0, 1'b1, 2'd3},  // R4 one short
    {4'd3, 4'd0,  1'b1, 1'b1, 2'd2},  // R7 tie rise/chop -> chop
    {4'd5, 4'd0,  1'b0, 1'b1, 2'd3},  // R4 write on rising cycle
    {4'd6, 4'd0,  1'b0, 1'b0, 2'd0},  // R4 write on rising cycle, legal
    {4'd4, 4'd3,  1'b1, 1'b1, 2'd2},  // R5 late chop extends hold
    {4'd3, 4'd1,  1'b0, 1'b1, 2'd3},  // R7 latest deadline wins
    {4'd7, 4'd1,  1'b0, 1'b0, 2'd0}   // R4 full hold from index 1
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    pulseCount += int'(violPulse);
  endtask

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doClear();
    clear = 1'b1;
    tick();
    clear = 1'b0;
    pulseCount = 0;
  endtask

  // One high stretch with optional write at wrAt; returns with ODT low sampled.
  task automatic runPulse(input int len, input int wrAt, input logic chop);
    for (int i = 0; i < len; i++) begin
      odtIn   = 1'b1;
      wrValid = (i == wrAt);
      wrChop  = chop;
      tick();
    end
    odtIn   = 1'b0;
    wrValid = 1'b0;
    tick();
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: ODT high during reset; outputs zero, first sample counts as a rise.
    odtIn = 1'b1;
    repeat (3) @(negedge clk);
    check(int'(violFlag), 0, "R1 flag in reset");
    check(int'(violCode), 0, "R1 code in reset");
    check(int'(violPulse), 0, "R1 pulse in reset");
    rstN = 1'b1;
    tick();
    tick();
    odtIn = 1'b0;
    tick();
    check(int'(violFlag), 1, "R1 high at reset release is a rise");
    check(int'(violCode), 1, "R1 code rise");

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      int hl;
      int wa;
      hl = int'(VEC[v][11:8]);
      wa = (VEC[v][7:4] == 4'd15) ? -1 : int'(VEC[v][7:4]);
      odtIn = 1'b0;
      doClear();
      tick();
      runPulse(hl, wa, VEC[v][3]);
      check(int'(violFlag), int'(VEC[v][2]), $sformatf("R2-vector %0d flag (R3 R4 R5 R7)", v));
      check(int'(violCode), int'(VEC[v][1:0]), $sformatf("R7 vector %0d code", v));
      tick();
      check(pulseCount, int'(VEC[v][2]), $sformatf("R8 vector %0d pulse count", v));
    end

    // R5: later chop write cannot shorten an earlier full-write hold.
    doClear();
    odtIn = 1'b1; wrValid = 1'b1; wrChop = 1'b0; tick();
    wrChop = 1'b1; tick();
    wrValid = 1'b0;
    tick(); tick(); tick();
    odtIn = 1'b0; tick();
    check(int'(violFlag), 1, "R5 no shortening flag");
    check(int'(violCode), 3, "R5 no shortening code");

    // R6: write while ODT low starts nothing.
    doClear();
    wrValid = 1'b1; wrChop = 1'b0; tick();
    wrValid = 1'b0;
    runPulse(4, -1, 1'b0);
    tick();
    check(int'(violFlag), 0, "R6 write while low ignored");
    check(pulseCount, 0, "R6 no pulse");

    // R8: stickiness across a compliant pulse, then code update.
    doClear();
    runPulse(2, -1, 1'b0);
    check(int'(violPulse), 1, "R8 pulse visible");
    tick();
    check(int'(violPulse), 0, "R8 pulse one cycle");
    runPulse(6, -1, 1'b0);
    tick();
    check(int'(violFlag), 1, "R8 flag sticky");
    check(int'(violCode), 1, "R8 code held");
    runPulse(3, 1, 1'b0);
    check(int'(violCode), 3, "R8 code updated by new violation");
    check(pulseCount, 2, "R8 pulse count");

    // R9: clear zeroes flag and code.
    doClear();
    check(int'(violFlag), 0, "R9 flag cleared");
    check(int'(violCode), 0, "R9 code cleared");

    // R9: clear during a hold drops it; ODT held high is not a new rise.
    odtIn = 1'b1; wrValid = 1'b1; wrChop = 1'b0; tick();
    wrValid = 1'b0; tick();
    clear = 1'b1; tick();
    clear = 1'b0; tick();
    odtIn = 1'b0; tick();
    tick();
    check(int'(violFlag), 0, "R9 hold dropped by clear");
    check(pulseCount, 0, "R9 no pulse after clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule